// File: doc/BRIEF.md
# I2C Master Receiver Controller

This block is a byte-level I2C master that reads data from a slave device. A host drives it through a small register interface. A control write carries four request bits: start, stop, acknowledge-enable and a flag-clear. A data write loads the byte to be sent. A data read returns the last received byte. The block reports each completed bus event as an 8-bit status code and raises an interrupt flag. It then keeps SCL low until the host writes the control register with the clear bit set. The request bits present at that moment pick the next bus action.

The block can generate START, repeated START and STOP. It sends the address-plus-read byte and receives data bytes, returning ACK or NACK for each one. It detects arbitration loss and divides the system clock down to SCL. SDA and SCL are open-drain: an output-enable of 1 pulls the line low. Bytes are shifted MSB first. A START or STOP is the only SDA edge made while SCL is high. A START request from idle, or after arbitration loss, waits until the bus is free. The bus counts as busy from a START seen on the lines until the next STOP seen on the lines.

Top module: `i2c_mrx_ctrl`

## Requirements
- R1: A control write with start=1 while idle and the bus is free generates a START condition. When the START is complete, the block reports status 0x08 and sets the interrupt flag.
- R2: The host may clear the flag at status 0x48 or 0x58 with start=1 and stop=0. The block then sends a repeated START without releasing the bus and reports 0x10.
- R3: Clearing the flag at status 0x08 or 0x10 sends the loaded byte MSB first and then reads the slave's acknowledge bit. An acknowledge that reads low gives status 0x40; one that reads high gives 0x48.
- R4: Clearing the flag at status 0x40 or 0x50 receives one byte MSB first. The byte is then readable on data_o.
  - The block returns ACK (SDA low) when acknowledge-enable is 1 and reports 0x50.
  - It returns NACK (SDA released) when acknowledge-enable is 0 and reports 0x58.
- R5: Clearing the flag at status 0x48 or 0x58 with start=0 and stop=1 generates a STOP. When the STOP is complete:
  - the stop request bit clears by itself;
  - status reads 0xF8;
  - the flag stays clear;
  - both lines are released.
- R6: Clearing the flag at status 0x48 or 0x58 with start=1 and stop=1 generates a STOP followed by a fresh START. The block then reports 0x08, not 0x10.
- R7: Arbitration is lost when the block releases SDA and samples it low during the SCL high phase of an address bit or a NACK bit. The block then releases both lines, reports 0x38 and sets the flag.
- R8: Clearing the flag at 0x38 depends on the start bit.
  - With start=0, the block goes idle: status 0xF8, flag clear.
  - With start=1, it sends a START only after a STOP has been seen on the bus, then reports 0x08.
- R9: Once set, the interrupt flag stays set until a control write with clear=1. While it is set and the status is not 0x38, SCL is held low.
- R10: The three low bits of the status byte always read zero. Status 0xF8 appears only while the interrupt flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_start_i | input | 1 | Start request bit for the control write |
| ctrl_stop_i | input | 1 | Stop request bit for the control write |
| ctrl_ack_i | input | 1 | Acknowledge-enable bit for the control write |
| ctrl_clr_i | input | 1 | Writing 1 clears the interrupt flag and releases the next action |
| data_we_i | input | 1 | Data register write strobe |
| data_i | input | 8 | Byte to send (the address byte) |
| data_o | output | 8 | Data register contents (the last received byte) |
| status_o | output | 8 | Status code; low three bits always zero |
| irq_o | output | 1 | Interrupt flag |
| start_o | output | 1 | Start request bit readback |
| stop_o | output | 1 | Stop request bit readback; clears itself after a STOP |
| ack_o | output | 1 | Acknowledge-enable readback |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe_o | output | 1 | Pull SCL low when 1 |
| sda_oe_o | output | 1 | Pull SDA low when 1 |

## Verification
Some properties are checked on every cycle:
- the zero low bits of the status byte;
- that 0xF8 never appears with the flag set;
- that the flag persists until a clear write;
- that SCL is held low under a pending non-arbitration status;
- that both lines are released under 0x38;
- that every rising flag carries a legal code and a self-cleared stop lands on 0xF8 with no flag.

Other behaviour only the bench scenarios can show:
- the order of status codes across a full transfer;
- MSB-first bit order against a behavioural slave;
- the ACK and NACK values the slave actually sees;
- that STOP-then-START gives 0x08 while a plain repeated START gives 0x10;
- that a queued START waits for a foreign STOP.

// File: rtl/i2c_mrx_pkg.sv
package i2c_mrx_pkg;
  typedef enum logic [1:0] {CMD_START, CMD_STOP, CMD_BIT} cmd_e;
  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT_FREE, ST_START, ST_ADDR, ST_RX, ST_STOP, ST_HOLD, ST_DISP
  } state_e;
  localparam logic [7:0] SC_START    = 8'h08;
  localparam logic [7:0] SC_RSTART   = 8'h10;
  localparam logic [7:0] SC_ARB      = 8'h38;
  localparam logic [7:0] SC_SLA_ACK  = 8'h40;
  localparam logic [7:0] SC_SLA_NACK = 8'h48;
  localparam logic [7:0] SC_RX_ACK   = 8'h50;
  localparam logic [7:0] SC_RX_NACK  = 8'h58;
  localparam logic [7:0] SC_IDLE     = 8'hF8;
endpackage

// File: rtl/i2c_mrx_tick.sv
module i2c_mrx_tick #(
  parameter int unsigned DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/i2c_mrx_bitctl.sv
module i2c_mrx_bitctl
  import i2c_mrx_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic cmd_valid_i,
  input  cmd_e cmd_i,
  input  logic bit_i,
  input  logic chk_i,
  input  logic sda_i,
  output logic busy_o,
  output logic done_o,
  output logic rx_o,
  output logic arb_o,
  output logic scl_oe_o,
  output logic sda_oe_o
);
  logic       run_q, bit_q, chk_q, scl_oe_q, sda_oe_q, rx_q, done_q, arb_q;
  logic [1:0] ph_q;
  cmd_e       cmd_q;

  // four phases per command, one per tick: set SDA, raise SCL, act at SCL high, lower SCL
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0; ph_q <= '0; cmd_q <= CMD_BIT; bit_q <= 1'b1; chk_q <= 1'b0;
      scl_oe_q <= 1'b0; sda_oe_q <= 1'b0; rx_q <= 1'b1; done_q <= 1'b0; arb_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      arb_q  <= 1'b0;
      if (!run_q) begin
        if (cmd_valid_i) begin
          run_q <= 1'b1; ph_q <= '0; cmd_q <= cmd_i; bit_q <= bit_i; chk_q <= chk_i;
        end
      end else if (tick_i) begin
        ph_q <= ph_q + 2'd1;
        case (ph_q)
          2'd0: begin
            case (cmd_q)
              CMD_START: sda_oe_q <= 1'b0;
              CMD_STOP:  sda_oe_q <= 1'b1;
              default:   sda_oe_q <= ~bit_q;
            endcase
          end
          2'd1: scl_oe_q <= 1'b0;
          2'd2: begin
            case (cmd_q)
              CMD_START: sda_oe_q <= 1'b1;
              CMD_STOP:  sda_oe_q <= 1'b0;
              default: begin
                rx_q <= sda_i;
                if (chk_q && bit_q && !sda_i) begin
                  arb_q    <= 1'b1;
                  done_q   <= 1'b1;
                  run_q    <= 1'b0;
                  sda_oe_q <= 1'b0;
                end
              end
            endcase
          end
          default: begin
            if (cmd_q != CMD_STOP) scl_oe_q <= 1'b1;
            done_q <= 1'b1;
            run_q  <= 1'b0;
          end
        endcase
      end
    end
  end

  assign busy_o   = run_q;
  assign done_o   = done_q;
  assign rx_o     = rx_q;
  assign arb_o    = arb_q;
  assign scl_oe_o = scl_oe_q;
  assign sda_oe_o = sda_oe_q;
endmodule

// File: rtl/i2c_mrx_ctrl.sv
module i2c_mrx_ctrl
  import i2c_mrx_pkg::*;
#(
  parameter int unsigned CLK_DIV = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ctrl_we_i,
  input  logic       ctrl_start_i,
  input  logic       ctrl_stop_i,
  input  logic       ctrl_ack_i,
  input  logic       ctrl_clr_i,
  input  logic       data_we_i,
  input  logic [7:0] data_i,
  output logic [7:0] data_o,
  output logic [7:0] status_o,
  output logic       irq_o,
  output logic       start_o,
  output logic       stop_o,
  output logic       ack_o,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe_o,
  output logic       sda_oe_o
);
  localparam int unsigned BITS = 8;
  localparam logic [3:0]  LAST_BIT = 4'(BITS);

  state_e     state_q;
  logic       sta_q, sto_q, ea_q, irq_q, pend_q, owned_q, bb_q, scl_d, sda_d;
  logic [7:0] status_q, dr_q, sh_q;
  logic [3:0] cnt_q;

  logic tick, eng_busy, eng_done, eng_rx, eng_arb;
  logic cmd_valid, bit_v, chk_v, active;
  cmd_e cmd;

  i2c_mrx_tick #(.DIV(CLK_DIV)) u_tick (.clk_i(clk_i), .rst_ni(rst_ni), .tick_o(tick));

  i2c_mrx_bitctl u_bit (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick),
    .cmd_valid_i(cmd_valid), .cmd_i(cmd), .bit_i(bit_v), .chk_i(chk_v),
    .sda_i(sda_i), .busy_o(eng_busy), .done_o(eng_done), .rx_o(eng_rx),
    .arb_o(eng_arb), .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o)
  );

  always_comb begin
    active    = (state_q == ST_START) || (state_q == ST_ADDR) ||
                (state_q == ST_RX)    || (state_q == ST_STOP);
    cmd_valid = active && !pend_q;
    cmd       = CMD_BIT;
    bit_v     = 1'b1;
    chk_v     = 1'b0;
    case (state_q)
      ST_START: cmd = CMD_START;
      ST_STOP:  cmd = CMD_STOP;
      ST_ADDR: begin
        bit_v = (cnt_q < LAST_BIT) ? sh_q[7] : 1'b1;
        chk_v = (cnt_q < LAST_BIT);
      end
      ST_RX: begin
        bit_v = (cnt_q < LAST_BIT) ? 1'b1 : ~ea_q;
        chk_v = (cnt_q == LAST_BIT);
      end
      default: ;
    endcase
  end

  // bus-free tracking from START/STOP seen on the lines
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_d <= 1'b1; sda_d <= 1'b1; bb_q <= 1'b0;
    end else begin
      scl_d <= scl_i;
      sda_d <= sda_i;
      if (scl_i && scl_d && sda_d && !sda_i)      bb_q <= 1'b1;
      else if (scl_i && scl_d && !sda_d && sda_i) bb_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE; sta_q <= 1'b0; sto_q <= 1'b0; ea_q <= 1'b0;
      irq_q <= 1'b0; pend_q <= 1'b0; owned_q <= 1'b0;
      status_q <= SC_IDLE; dr_q <= '0; sh_q <= '0; cnt_q <= '0;
    end else begin
      if (ctrl_we_i) begin
        sta_q <= ctrl_start_i; sto_q <= ctrl_stop_i; ea_q <= ctrl_ack_i;
      end
      if (data_we_i) dr_q <= data_i;
      if (cmd_valid && !eng_busy) pend_q <= 1'b1;
      if (eng_done)               pend_q <= 1'b0;

      case (state_q)
        ST_IDLE:      if (sta_q) state_q <= ST_WAIT_FREE;
        ST_WAIT_FREE: if (!bb_q) state_q <= ST_START;
        ST_START: if (eng_done) begin
          status_q <= owned_q ? SC_RSTART : SC_START;
          owned_q  <= 1'b1;
          irq_q    <= 1'b1;
          state_q  <= ST_HOLD;
        end
        ST_ADDR, ST_RX: if (eng_done) begin
          if (eng_arb) begin
            status_q <= SC_ARB; owned_q <= 1'b0; irq_q <= 1'b1;
            cnt_q <= '0; state_q <= ST_HOLD;
          end else if (cnt_q < LAST_BIT) begin
            sh_q  <= {sh_q[6:0], eng_rx};
            cnt_q <= cnt_q + 4'd1;
            if (state_q == ST_RX && cnt_q == LAST_BIT - 4'd1) dr_q <= {sh_q[6:0], eng_rx};
          end else begin
            // the ack bit value on the line selects the code
            if (state_q == ST_ADDR) status_q <= eng_rx ? SC_SLA_NACK : SC_SLA_ACK;
            else                    status_q <= eng_rx ? SC_RX_NACK : SC_RX_ACK;
            irq_q <= 1'b1; cnt_q <= '0; state_q <= ST_HOLD;
          end
        end
        ST_STOP: if (eng_done) begin
          sto_q    <= 1'b0;
          owned_q  <= 1'b0;
          status_q <= SC_IDLE;
          state_q  <= sta_q ? ST_WAIT_FREE : ST_IDLE;
        end
        ST_HOLD: if (ctrl_we_i && ctrl_clr_i) begin
          irq_q   <= 1'b0;
          state_q <= ST_DISP;
        end
        ST_DISP: begin
          case (status_q)
            SC_START, SC_RSTART: begin sh_q <= dr_q; cnt_q <= '0; state_q <= ST_ADDR; end
            SC_SLA_ACK, SC_RX_ACK: begin cnt_q <= '0; state_q <= ST_RX; end
            SC_SLA_NACK, SC_RX_NACK: state_q <= (sta_q && !sto_q) ? ST_START : ST_STOP;
            SC_ARB: begin
              status_q <= SC_IDLE;
              state_q  <= sta_q ? ST_WAIT_FREE : ST_IDLE;
            end
            default: state_q <= ST_IDLE;
          endcase
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign data_o   = dr_q;
  assign status_o = status_q;
  assign irq_o    = irq_q;
  assign start_o  = sta_q;
  assign stop_o   = sto_q;
  assign ack_o    = ea_q;
endmodule

// File: rtl/i2c_mrx_ctrl_chk.sv
module i2c_mrx_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ctrl_we_i,
  input logic       ctrl_clr_i,
  input logic [7:0] status_o,
  input logic       irq_o,
  input logic       stop_o,
  input logic       scl_oe_o,
  input logic       sda_oe_o
);
  // R10
  status_low_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[2:0] == 3'b000);

  // R10
  idle_code_no_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> status_o != 8'hF8);

  // R9
  irq_persist_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !(ctrl_we_i && ctrl_clr_i) |=> irq_o);

  // R9
  scl_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && status_o != 8'h38 |-> scl_oe_o);

  // R7
  arb_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && status_o == 8'h38 |-> !scl_oe_o && !sda_oe_o);

  // R1
  irq_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> (status_o == 8'h08 || status_o == 8'h10 || status_o == 8'h38 ||
                      status_o == 8'h40 || status_o == 8'h48 || status_o == 8'h50 ||
                      status_o == 8'h58));

  // R5
  stop_self_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(stop_o) && !$past(ctrl_we_i) |-> status_o == 8'hF8 && !irq_o && !sda_oe_o);
endmodule

bind i2c_mrx_ctrl i2c_mrx_ctrl_chk chk_u (
  .clk_i(clk_i), .rst_ni(rst_ni), .ctrl_we_i(ctrl_we_i), .ctrl_clr_i(ctrl_clr_i),
  .status_o(status_o), .irq_o(irq_o), .stop_o(stop_o),
  .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o)
);

// File: tb/i2c_mrx_ctrl_tb_top.sv
module i2c_mrx_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 4;
  localparam logic [6:0] SLV_ADDR = 7'h50;

  logic clk = 1'b0, rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic       ctrl_we = 0, ctrl_start = 0, ctrl_stop = 0, ctrl_ack = 0, ctrl_clr = 0;
  logic       data_we = 0;
  logic [7:0] data_in = 0;
  logic [7:0] data_out, status;
  logic       irq, start_rb, stop_rb, ack_rb, scl_oe, sda_oe;
  logic       sl_oe = 1'b0, comp_oe = 1'b0;
  logic       scl_line, sda_line;

  assign scl_line = !scl_oe;
  assign sda_line = !(sda_oe || sl_oe || comp_oe);

  i2c_mrx_ctrl #(.CLK_DIV(DIV)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .ctrl_we_i(ctrl_we), .ctrl_start_i(ctrl_start), .ctrl_stop_i(ctrl_stop),
    .ctrl_ack_i(ctrl_ack), .ctrl_clr_i(ctrl_clr),
    .data_we_i(data_we), .data_i(data_in), .data_o(data_out), .status_o(status),
    .irq_o(irq), .start_o(start_rb), .stop_o(stop_rb), .ack_o(ack_rb),
    .scl_i(scl_line), .sda_i(sda_line), .scl_oe_o(scl_oe), .sda_oe_o(sda_oe)
  );

  int checks = 0, bad = 0, hold_viol = 0;
  bit finished = 0;

  // behavioural slave and bus monitor
  int         sl_state = 0, sl_bit = 0, starts_seen = 0, stops_seen = 0;
  logic [7:0] sl_sh = 0, sl_tx = 0, addr_seen = 0;
  logic       sl_ok = 0, sc_p = 1, sd_p = 1;
  logic [7:0] tx_q[$];
  logic       mack_q[$];

  always @(negedge clk) begin
    if (rst_n) begin
      if (irq && status != 8'h38 && scl_line) hold_viol++;
      if (sc_p && scl_line && sd_p && !sda_line) begin
        starts_seen++; sl_state = 1; sl_bit = 0; sl_oe = 0;
      end else if (sc_p && scl_line && !sd_p && sda_line) begin
        stops_seen++; sl_state = 0; sl_oe = 0;
      end else if (!sc_p && scl_line) begin
        if (sl_state == 1 && sl_bit < 8) sl_sh = {sl_sh[6:0], sda_line};
        if (sl_state == 2 && sl_bit == 8) mack_q.push_back(sda_line);
        if (sl_state != 0) sl_bit++;
      end else if (sc_p && !scl_line) begin
        if (sl_state == 1) begin
          if (sl_bit == 8) begin
            addr_seen = sl_sh;
            sl_ok = (sl_sh[7:1] == SLV_ADDR);
            sl_oe = sl_ok;
          end else if (sl_bit == 9) begin
            if (sl_ok && sl_sh[0]) begin
              sl_tx = (tx_q.size() > 0) ? tx_q.pop_front() : 8'hFF;
              sl_state = 2; sl_bit = 0; sl_oe = ~sl_tx[7];
            end else begin
              sl_state = 0; sl_oe = 0;
            end
          end
        end else if (sl_state == 2) begin
          if (sl_bit >= 1 && sl_bit <= 7) sl_oe = ~sl_tx[7-sl_bit];
          else if (sl_bit == 8) sl_oe = 0;
          else if (sl_bit == 9) begin
            if (mack_q.size() > 0 && mack_q[mack_q.size()-1] == 1'b0) begin
              sl_tx = (tx_q.size() > 0) ? tx_q.pop_front() : 8'hFF;
              sl_bit = 0; sl_oe = ~sl_tx[7];
            end else begin
              sl_state = 0; sl_oe = 0;
            end
          end
        end
      end
    end
    sc_p = scl_line;
    sd_p = sda_line;
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ctrl(input logic s, input logic p, input logic a, input logic c);
    @(negedge clk);
    ctrl_we = 1; ctrl_start = s; ctrl_stop = p; ctrl_ack = a; ctrl_clr = c;
    @(negedge clk);
    ctrl_we = 0; ctrl_clr = 0;
  endtask

  task automatic load(input logic [7:0] d);
    @(negedge clk);
    data_we = 1; data_in = d;
    @(negedge clk);
    data_we = 0;
  endtask

  task automatic wait_irq(input string req);
    int n = 0;
    while (!irq && n < 5000) begin @(negedge clk); n++; end
    chk({req, " irq"}, {7'd0, irq}, 8'd1);
  endtask

  task automatic wait_stop(input string req);
    int n = 0;
    while (stop_rb && n < 5000) begin @(negedge clk); n++; end
    repeat (2) @(negedge clk);
    chk({req, " stop bit self-clear"}, {7'd0, stop_rb}, 8'd0);
    chk({req, " idle status"}, status, 8'hF8);
    chk({req, " irq clear"}, {7'd0, irq}, 8'd0);
    chk({req, " lines released"}, {6'd0, scl_line, sda_line}, 8'd3);
  endtask

  task automatic summary();
    finished = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      summary();
    end
  end

  initial begin
    int st0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 reset status", status, 8'hF8);
    chk("R10 reset irq/lines", {5'd0, irq, scl_oe, sda_oe}, 8'd0);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 / R9 / R3 / R4 read of two bytes
    tx_q.push_back(8'h3A); tx_q.push_back(8'h96);
    load(8'hA1);
    ctrl(1, 0, 1, 0);
    wait_irq("R1");
    chk("R1 start code", status, 8'h08);
    repeat (100) @(negedge clk);
    chk("R9 flag persists", {7'd0, irq}, 8'd1);
    chk("R9 scl held low", {7'd0, scl_line}, 8'd0);
    ctrl(0, 0, 1, 1);
    wait_irq("R3");
    chk("R3 addr ack code", status, 8'h40);
    chk("R3 addr msb first", addr_seen, 8'hA1);
    ctrl(0, 0, 1, 1);
    wait_irq("R4");
    chk("R4 ack code", status, 8'h50);
    chk("R4 byte msb first", data_out, 8'h3A);
    ctrl(0, 0, 0, 1);
    wait_irq("R4");
    chk("R4 nack code", status, 8'h58);
    chk("R4 second byte", data_out, 8'h96);
    chk("R4 master ack bits", {6'd0, mack_q[0], mack_q[1]}, 8'b01);

    // R2 repeated start
    st0 = stops_seen;
    ctrl(1, 0, 0, 1);
    wait_irq("R2");
    chk("R2 rstart code", status, 8'h10);
    chk("R2 no stop between", 8'(stops_seen - st0), 8'd0);
    tx_q.push_back(8'hC5);
    load(8'hA1);
    ctrl(0, 0, 0, 1);
    wait_irq("R3");
    chk("R3 ack after rstart", status, 8'h40);
    ctrl(0, 0, 0, 1);
    wait_irq("R4");
    chk("R4 nack byte", data_out, 8'hC5);
    // R5 stop
    ctrl(0, 1, 0, 1);
    wait_stop("R5");

    // R3 address nack, R6 stop then start
    load(8'hB1);
    ctrl(1, 0, 0, 0);
    wait_irq("R1");
    ctrl(0, 0, 0, 1);
    wait_irq("R3");
    chk("R3 addr nack code", status, 8'h48);
    st0 = stops_seen;
    ctrl(1, 1, 0, 1);
    wait_irq("R6");
    chk("R6 fresh start code", status, 8'h08);
    chk("R6 stop seen", 8'(stops_seen - st0), 8'd1);
    ctrl(0, 0, 0, 1);
    wait_irq("R3");
    ctrl(0, 1, 0, 1);
    wait_stop("R5");

    // R7 / R8 arbitration, release to idle
    load(8'hA1);
    ctrl(1, 0, 0, 0);
    wait_irq("R1");
    @(negedge clk); comp_oe = 1;
    ctrl(0, 0, 0, 1);
    wait_irq("R7");
    chk("R7 arb code", status, 8'h38);
    chk("R7 lines released", {6'd0, scl_oe, sda_oe}, 8'd0);
    ctrl(0, 0, 0, 1);
    repeat (20) @(negedge clk);
    chk("R8 idle after arb", status, 8'hF8);
    chk("R8 no irq after arb", {7'd0, irq}, 8'd0);
    @(negedge clk); comp_oe = 0;
    repeat (20) @(negedge clk);

    // R8 queued start waits for bus free
    ctrl(1, 0, 0, 0);
    wait_irq("R1");
    @(negedge clk); comp_oe = 1;
    ctrl(0, 0, 0, 1);
    wait_irq("R7");
    chk("R7 arb code 2", status, 8'h38);
    st0 = starts_seen;
    ctrl(1, 0, 0, 1);
    repeat (300) @(negedge clk);
    chk("R8 start waits", {7'd0, irq}, 8'd0);
    chk("R8 no start on busy bus", 8'(starts_seen - st0), 8'd0);
    comp_oe = 0;
    wait_irq("R8");
    chk("R8 queued start code", status, 8'h08);
    tx_q.push_back(8'h77);
    ctrl(0, 0, 0, 1);
    wait_irq("R3");
    chk("R3 ack after queued start", status, 8'h40);
    ctrl(0, 0, 0, 1);
    wait_irq("R4");
    chk("R4 byte after queued start", data_out, 8'h77);
    ctrl(0, 1, 0, 1);
    wait_stop("R5");

    // R9 per-cycle hold monitor
    chk("R9 scl held whenever flag set", 8'(hold_viol), 8'd0);
    summary();
  end
endmodule